// File: doc/BRIEF.md
# Data Link HDLC / Bit-Oriented Message Receive Switch

This block sits on the receive data-link channel of a framed line and takes one serial bit per strobe. It decides whether that channel is carrying HDLC frames or repeating bit-oriented message (BOM) codewords. When the channel carries HDLC, each bit is handed on to a downstream HDLC receiver through a bit/valid pair. When it carries BOM codewords, the block extracts the six-bit message from each codeword and presents it with a one-cycle valid pulse.

HDLC and BOM reception each have their own enable. With only one of them enabled, the block stays fixed in that mode. With both enabled, the block switches on its own. A run of eight ones while in HDLC mode moves it to BOM mode. An HDLC flag seen while in BOM mode moves it back.

A report-mode input chooses between two behaviours. In the first, every codeword is reported. In the second, a message is reported only when the same codeword arrives back to back, and only once for each run of repeats.

Top module: `dlink_mode_switch`

## Requirements
- R1: While reset is held and on the first clock after it, `modeBom`, `msgValid` and `hdlcBitValid` are 0, so the block starts in HDLC mode.
- R2: With `hdlcEn`=1 and `bomEn`=0, `modeBom` is 0 from the next clock on, whatever bits arrive (including long runs of ones), and `msgValid` never pulses.
- R3: With `hdlcEn`=0 and `bomEn`=1, `modeBom` is 1 from the next clock on, no flag brings it back, and `hdlcBitValid` never pulses.
- R4: With both enabled and `modeBom`=0, the strobe that completes eight consecutive ones sets `modeBom` on the following clock. The bit of that strobe is still passed to the HDLC output.
- R5: With both enabled and `modeBom`=1, the strobe that completes the sequence 0,1,1,1,1,1,1,0 (first to last) clears `modeBom` on the following clock. The exception is when the same last 16 bits form a valid codeword, in which case the mode stays BOM.
- R6: A codeword is the last 16 strobed bits, first to last: eight ones, a zero, message bits m5..m0, a zero. The first message bit received is bit 5 of `msgData`. A report shows as `msgValid`=1 for exactly the one clock after the completing strobe, with `msgData` holding the message from then on.
- R7: With `repeatMode`=0, every codeword recognised in BOM mode is reported.
- R8: With `repeatMode`=1, a codeword is reported only if the previous codeword had the same message and ended on the strobe just before this codeword's first bit. After such a report, further back-to-back repeats are not reported. A different message, or any extra strobe between codewords, starts the count again.
- R9: A 16-bit window that does not match the codeword pattern produces no report, and no report is made while in HDLC mode.
- R10: In HDLC mode with `hdlcEn`=1, each strobe makes `hdlcBitValid`=1 for the one following clock, with `hdlcBit` equal to the strobed bit. In BOM mode, or with `hdlcEn`=0, no bit is passed.
- R11: A change of the enables takes effect on `modeBom` one clock later without any strobe. Enabling both keeps the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data-link bit |
| bitStrobe | input | 1 | Qualifies `bitIn` for one clock |
| hdlcEn | input | 1 | Enables HDLC reception |
| bomEn | input | 1 | Enables BOM reception |
| repeatMode | input | 1 | 0: report every codeword, 1: report confirmed repeats once |
| modeBom | output | 1 | Current mode, 1 = BOM, 0 = HDLC |
| msgData | output | 6 | Last reported message, first-received bit as MSB |
| msgValid | output | 1 | One-clock pulse for a new report |
| hdlcBit | output | 1 | Bit passed to the HDLC receiver |
| hdlcBitValid | output | 1 | One-clock pulse qualifying `hdlcBit` |

## Verification
The bench uses the default build: an eight-bit ones run, a six-bit message and so a 16-bit window. With these values the back-to-back test hits the gap count of exactly fifteen strobes between codewords, and a single extra bit breaks a repeat run. A 111111 message places a flag pattern at the end of a codeword, which tests codeword priority over the flag. Long HDLC stretches in the random phase drive the strobe gap counter into saturation before BOM mode is entered again.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic codeTake;
    logic passBit;
    logic histClr;
  } dlrxCtl_t;

  // pattern hits from datapath to control
  typedef struct packed {
    logic runSeen;
    logic flagSeen;
    logic codeSeen;
  } dlrxStat_t;

endpackage

// File: rtl/dlrx_datapath.sv
module dlrx_datapath
  import dlrx_pkg::*;
#(
  parameter int RUN_W = 8,
  parameter int MSG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             repeatMode,
  input  dlrxCtl_t         ctl,
  output dlrxStat_t        stat,
  output logic [MSG_W-1:0] msgData,
  output logic             msgValid,
  output logic             hdlcBit,
  output logic             hdlcBitValid
);

  localparam int WIN_W = RUN_W + MSG_W + 2;
  localparam int GAP_W = $clog2(WIN_W) + 1;
  localparam logic [GAP_W-1:0] GAP_BACK = GAP_W'(WIN_W - 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;

  logic [WIN_W-2:0] shiftQ;
  logic [WIN_W-1:0] window;
  logic [MSG_W-1:0] codeMsg;
  logic [GAP_W-1:0] gapQ;
  logic [MSG_W-1:0] histMsgQ;
  logic             histValidQ;
  logic             sentQ;
  logic [MSG_W-1:0] msgQ;
  logic             msgValidQ;
  logic             hdlcBitQ;
  logic             hdlcValidQ;
  logic             backToBack;

  // newest bit in the LSB
  assign window  = {shiftQ, bitIn};
  assign codeMsg = window[MSG_W:1];

  assign stat.runSeen  = &window[RUN_W-1:0];
  assign stat.flagSeen = (window[7:0] == FLAG_BYTE);
  assign stat.codeSeen = (&window[WIN_W-1 -: RUN_W]) && !window[MSG_W+1] && !window[0];

  assign backToBack = histValidQ && (gapQ == GAP_BACK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ     <= '0;
      gapQ       <= '0;
      histMsgQ   <= '0;
      histValidQ <= 1'b0;
      sentQ      <= 1'b0;
      msgQ       <= '0;
      msgValidQ  <= 1'b0;
      hdlcBitQ   <= 1'b0;
      hdlcValidQ <= 1'b0;
    end else begin
      msgValidQ  <= 1'b0;
      hdlcValidQ <= ctl.passBit;
      if (ctl.passBit) hdlcBitQ <= bitIn;

      if (ctl.shiftEn) begin
        shiftQ <= window[WIN_W-2:0];
        if (ctl.codeTake)       gapQ <= '0;
        else if (gapQ != GAP_MAX) gapQ <= gapQ + 1'b1;
      end

      if (ctl.histClr) begin
        histValidQ <= 1'b0;
        sentQ      <= 1'b0;
      end else if (ctl.codeTake) begin
        histValidQ <= 1'b1;
        histMsgQ   <= codeMsg;
        if (!repeatMode) begin
          msgQ      <= codeMsg;
          msgValidQ <= 1'b1;
        end else if (backToBack && (histMsgQ == codeMsg)) begin
          if (!sentQ) begin
            msgQ      <= codeMsg;
            msgValidQ <= 1'b1;
            sentQ     <= 1'b1;
          end
        end else begin
          sentQ <= 1'b0;
        end
      end
    end
  end

  assign msgData      = msgQ;
  assign msgValid     = msgValidQ;
  assign hdlcBit      = hdlcBitQ;
  assign hdlcBitValid = hdlcValidQ;

  // R10
  no_dual_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValidQ && hdlcValidQ));

  // R6
  msg_from_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValidQ |-> $past(ctl.codeTake));

  // R8
  repeat_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValidQ && $past(repeatMode)) |-> !$past(sentQ));

endmodule

// File: rtl/dlrx_control.sv
module dlrx_control
  import dlrx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStrobe,
  input  logic      hdlcEn,
  input  logic      bomEn,
  input  dlrxStat_t stat,
  output dlrxCtl_t  ctl,
  output logic      modeBom
);

  logic modeQ;
  logic modeD;

  always_comb begin
    modeD = modeQ;
    if (!bomEn) begin
      modeD = 1'b0;
    end else if (!hdlcEn) begin
      modeD = 1'b1;
    end else if (bitStrobe) begin
      if (!modeQ && stat.runSeen)                       modeD = 1'b1;
      else if (modeQ && stat.flagSeen && !stat.codeSeen) modeD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= modeD;
  end

  assign ctl.shiftEn  = bitStrobe;
  assign ctl.codeTake = bitStrobe && modeQ && bomEn && stat.codeSeen;
  assign ctl.passBit  = bitStrobe && !modeQ && hdlcEn;
  assign ctl.histClr  = !modeQ || !bomEn;
  assign modeBom      = modeQ;

  // R2
  hdlc_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdlcEn && !bomEn) |=> !modeBom);

  // R3
  bom_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hdlcEn && bomEn) |=> modeBom);

  // R4
  run_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeBom && hdlcEn && bomEn && bitStrobe && stat.runSeen) |=> modeBom);

  // R5
  flag_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBom && hdlcEn && bomEn && bitStrobe && stat.flagSeen && !stat.codeSeen) |=> !modeBom);

endmodule

// File: rtl/dlink_mode_switch.sv
module dlink_mode_switch
  import dlrx_pkg::*;
#(
  parameter int RUN_W = 8,
  parameter int MSG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             bitStrobe,
  input  logic             hdlcEn,
  input  logic             bomEn,
  input  logic             repeatMode,
  output logic             modeBom,
  output logic [MSG_W-1:0] msgData,
  output logic             msgValid,
  output logic             hdlcBit,
  output logic             hdlcBitValid
);

  dlrxCtl_t  ctl;
  dlrxStat_t stat;

  dlrx_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .bitStrobe(bitStrobe),
    .hdlcEn   (hdlcEn),
    .bomEn    (bomEn),
    .stat     (stat),
    .ctl      (ctl),
    .modeBom  (modeBom)
  );

  dlrx_datapath #(.RUN_W(RUN_W), .MSG_W(MSG_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .bitIn       (bitIn),
    .repeatMode  (repeatMode),
    .ctl         (ctl),
    .stat        (stat),
    .msgData     (msgData),
    .msgValid    (msgValid),
    .hdlcBit     (hdlcBit),
    .hdlcBitValid(hdlcBitValid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!modeBom && !msgValid && !hdlcBitValid));

endmodule

// File: tb/dlink_mode_switch_bench.sv
module dlink_mode_switch_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, bitIn, bitStrobe, hdlcEn, bomEn, repeatMode;
  logic       modeBom, msgValid, hdlcBit, hdlcBitValid;
  logic [5:0] msgData;

  dlink_mode_switch u_dlink_mode_switch (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitStrobe(bitStrobe),
    .hdlcEn(hdlcEn), .bomEn(bomEn), .repeatMode(repeatMode),
    .modeBom(modeBom), .msgData(msgData), .msgValid(msgValid),
    .hdlcBit(hdlcBit), .hdlcBitValid(hdlcBitValid)
  );

  int vecs = 0;
  int errs = 0;
  int reports = 0;
  bit done = 1'b0;

  // expectation state
  logic [15:0] mHist;
  logic        mMode, mPrevOk, mSent;
  logic [5:0]  mPrev, lastMsg;
  int          mSince;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic isCode(input logic [15:0] w);
    return (w[15:8] == 8'hFF) && !w[7] && !w[0];
  endfunction

  function automatic logic nextMode(input logic cur, input logic [15:0] w, input logic h, input logic b);
    if (!b) return 1'b0;
    if (!h) return 1'b1;
    if (!cur && (w[7:0] == 8'hFF)) return 1'b1;
    if (cur && (w[7:0] == 8'h7E) && !isCode(w)) return 1'b0;
    return cur;
  endfunction

  task automatic sendBit(input logic b, input string tag);
    logic [15:0] w;
    logic        expPass, expV;
    logic [5:0]  expMsg;
    bitIn = b; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    w = {mHist[14:0], b};
    if (!mMode) begin mPrevOk = 1'b0; mSent = 1'b0; end
    expPass = !mMode && hdlcEn;
    expV = 1'b0; expMsg = lastMsg;
    if (mMode && bomEn && isCode(w)) begin
      if (!repeatMode) begin
        expV = 1'b1; expMsg = w[6:1];
      end else if (mPrevOk && mSince == 15 && mPrev == w[6:1]) begin
        if (!mSent) begin expV = 1'b1; expMsg = w[6:1]; mSent = 1'b1; end
      end else begin
        mSent = 1'b0;
      end
      mPrev = w[6:1]; mPrevOk = 1'b1; mSince = 0;
    end else if (mSince < 31) begin
      mSince++;
    end
    mMode = nextMode(mMode, w, hdlcEn, bomEn);
    mHist = w;
    if (expV) lastMsg = expMsg;
    if (msgValid === 1'b1) reports++;
    chk({tag, " mode"}, modeBom, mMode);
    chk({tag, " msgValid R9"}, msgValid, expV);
    if (expV) chk({tag, " msgData R6"}, msgData, expMsg);
    chk({tag, " hdlcBitValid R10"}, hdlcBitValid, expPass);
    if (expPass) chk({tag, " hdlcBit R10"}, hdlcBit, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!mMode) begin mPrevOk = 1'b0; mSent = 1'b0; end
      chk("idle msgValid R9", msgValid, 1'b0);
      chk("idle hdlcBitValid R10", hdlcBitValid, 1'b0);
    end
  endtask

  task automatic setEn(input logic h, input logic b, input logic r);
    hdlcEn = h; bomEn = b; repeatMode = r;
    @(negedge clk);
    if (!b) mMode = 1'b0;
    else if (!h) mMode = 1'b1;
    if (!mMode) begin mPrevOk = 1'b0; mSent = 1'b0; end
    chk("R11 enable change mode", modeBom, mMode);
  endtask

  task automatic sendCode(input logic [5:0] m, input string tag);
    for (int i = 0; i < 8; i++) sendBit(1'b1, tag);
    sendBit(1'b0, tag);
    for (int i = 5; i >= 0; i--) sendBit(m[i], tag);
    sendBit(1'b0, tag);
  endtask

  task automatic sendFlag(input string tag);
    sendBit(1'b0, tag);
    for (int i = 0; i < 6; i++) sendBit(1'b1, tag);
    sendBit(1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [5:0] prevMsg;
    void'($urandom(32'd2718));
    rstN = 1'b0; bitIn = 1'b0; bitStrobe = 1'b0;
    hdlcEn = 1'b0; bomEn = 1'b0; repeatMode = 1'b0;
    mHist = '0; mMode = 1'b0; mPrevOk = 1'b0; mSent = 1'b0;
    mPrev = '0; lastMsg = '0; mSince = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset modeBom", modeBom, 1'b0);
    chk("R1 reset msgValid", msgValid, 1'b0);
    chk("R1 reset hdlcBitValid", hdlcBitValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset modeBom", modeBom, 1'b0);

    // R2: HDLC only, long ones runs never enter BOM
    setEn(1'b1, 1'b0, 1'b0);
    reports = 0;
    for (int i = 0; i < 20; i++) sendBit(1'b1, "R2 ones");
    sendCode(6'h2C, "R2 code");
    chk("R2 no report", reports, 0);

    // R3, R7, R6, R9: BOM only
    setEn(1'b0, 1'b1, 1'b0);
    chk("R3 bom only mode", modeBom, 1'b1);
    sendFlag("R3 flag");
    chk("R3 flag ignored", modeBom, 1'b1);
    reports = 0;
    sendCode(6'h2C, "R7 code");
    chk("R6 message order", msgData, 6'h2C);
    sendCode(6'h2C, "R7 code");
    sendCode(6'h2C, "R7 code");
    chk("R7 every codeword", reports, 3);
    reports = 0;
    for (int i = 0; i < 9; i++) sendBit(1'b1, "R9 bad");
    for (int i = 0; i < 7; i++) sendBit(1'b0, "R9 bad");
    chk("R9 malformed not reported", reports, 0);

    // R8: repeat confirmation
    setEn(1'b0, 1'b1, 1'b1);
    reports = 0;
    sendCode(6'h0A, "R8");
    sendCode(6'h15, "R8");
    chk("R8 single not reported", reports, 0);
    sendCode(6'h15, "R8");
    chk("R8 confirmed", reports, 1);
    chk("R8 confirmed msg", msgData, 6'h15);
    sendCode(6'h15, "R8");
    sendCode(6'h15, "R8");
    chk("R8 once per run", reports, 1);
    sendCode(6'h0A, "R8");
    chk("R8 change not reported", reports, 1);
    sendCode(6'h0A, "R8");
    chk("R8 new run reported", reports, 2);
    sendBit(1'b0, "R8 gap");
    sendCode(6'h0A, "R8");
    chk("R8 gap restarts", reports, 2);
    sendCode(6'h0A, "R8");
    chk("R8 after gap", reports, 3);

    // R4, R5: both enabled, automatic switching
    setEn(1'b1, 1'b1, 1'b0);
    chk("R11 both keeps mode", modeBom, 1'b1);
    sendFlag("R5 flag");
    chk("R5 flag exits", modeBom, 1'b0);
    for (int i = 0; i < 7; i++) sendBit(1'b1, "R4 run");
    chk("R4 seven ones", modeBom, 1'b0);
    sendBit(1'b1, "R4 eighth");
    chk("R4 eight ones", modeBom, 1'b1);
    reports = 0;
    sendBit(1'b0, "R4");
    for (int i = 0; i < 6; i++) sendBit(1'b1, "R5 msg");
    sendBit(1'b0, "R5 msg");
    chk("R5 codeword beats flag", modeBom, 1'b1);
    chk("R5 codeword reported", reports, 1);
    chk("R5 all-ones message", msgData, 6'h3F);
    sendBit(1'b0, "R5");
    sendFlag("R5 flag");
    chk("R5 flag exits again", modeBom, 1'b0);

    // random mix
    prevMsg = 6'h11;
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 7)
        0: begin prevMsg = 6'($urandom); sendCode(prevMsg, "rand code"); end
        1, 2: sendCode(prevMsg, "rand repeat");
        3: sendFlag("rand flag");
        4: begin
          int n = 1 + ($urandom % 12);
          for (int k = 0; k < n; k++) sendBit(1'($urandom), "rand bits");
        end
        5: idle(1 + ($urandom % 3));
        default: if (($urandom % 4) == 0)
          setEn(1'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule